// File: doc/BRIEF.md
# Quaternary Uplink Scrambling Code Generator

This block produces the short complex scrambling sequence for one uplink user. A 24-bit user index picks the sequence. The index is split into three 8-bit fields. Two of the fields seed binary shift registers. The third field passes through a fixed transformation and then seeds an 8-stage shift register over Z4. On each chip, the least significant stage of each register is taken, and the three values are summed modulo 4 into one quaternary symbol. The symbol then becomes a pair of sign bits for the in-phase and quadrature branches.

The registers cycle with period 255. The block stretches each period to 256 chips: on the last chip it holds the registers and outputs the first chip's symbol again. After that it reseeds all three registers from the stored index fields and raises a period-start flag on the new chip 0. A chip-enable input sets the pace. A load strobe selects a new user at any time and restarts the period.

Top module: `scr_code_gen`

## Requirements
- R1: After a synchronous active-low reset the chip counter is 0, the period-start flag is 1, and the block behaves exactly as if index 0 had been loaded.
- R2: When `load_i` is high at a clock edge with reset inactive, the block captures `user_idx_i`. Bits 7:0 become field r, bits 15:8 become s, and bits 23:16 become t. The counter clears to 0 and the block shows chip 0 in the next cycle, whatever `chip_en_i` is. A load takes precedence over advancing, and reset takes precedence over a load.
- R3: The two binary registers start with stage k equal to bit k of s and of t respectively. Each advance shifts stage k+1 into stage k. The new stage 7 is stage7^stage5^stage1^stage0 in the s register and stage7^stage5^stage4^stage0 in the t register.
- R4: The quaternary register starts with stage k equal to 2·r[k] mod 4, except stage 0, which is 2·r[0]+1 mod 4. It shifts the same way as the binary registers. The new stage 7 is (3·q5 + q3 + 3·q2 + 2·q1 + 3·q0) mod 4. Because of the seed, the symbol on chip 0 is always odd.
- R5: On chips 0 to 254 the symbol is (q0 + 2·b0 + 2·c0) mod 4, where q0, b0 and c0 are the current stage-0 values.
- R6: On chip 255 the registers do not advance and the symbol equals the symbol of chip 0 of the same period.
- R7: The counter rises by one on each enabled chip from 0 to 255 and then wraps to 0. On the wrap all registers reseed from the stored fields, so the 256-chip sequence repeats. The period-start flag is high exactly when the counter is 0.
- R8: Sign bits, where 1 means −1: symbol 0 gives I=0, Q=0; symbol 1 gives I=1, Q=0; symbol 2 gives I=1, Q=1; symbol 3 gives I=0, Q=1.
- R9: While `chip_en_i` is low and no load or reset occurs, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Capture a new user index and restart the period |
| user_idx_i | input | 24 | User index {t, s, r} |
| chip_en_i | input | 1 | Advance one chip at this edge |
| sym_o | output | 2 | Quaternary symbol of the current chip |
| i_neg_o | output | 1 | In-phase sign, 1 = −1 |
| q_neg_o | output | 1 | Quadrature sign, 1 = −1 |
| chip_cnt_o | output | 8 | Current chip number, 0 to 255 |
| period_start_o | output | 1 | High on chip 0 |

## Verification
The hardest case to reach is a load or a stall that arrives exactly at chip 255. The outputs there come from the stored chip-0 symbol, not from the registers, and the next enabled edge has to choose correctly between reseeding, reloading and holding. The stimulus counts out exact runs of 255 enabled chips after a load, then drops the enable or pulses the load on that boundary. Long stretches with a randomly gated enable make wraps land while the enable is toggling. A cycle-level reference model in the bench tracks every one of these cases.

// File: rtl/scr_pkg.sv
// Package: shared sizes, feedback taps and seed helpers for the
// quaternary scrambling code generator. Assumes the three index fields
// are each STG bits wide.
package scr_pkg;
    localparam int STG    = 8;
    localparam int IDX_W  = 3 * STG;
    localparam int CHIPS  = 256;
    localparam int CNT_W  = $clog2(CHIPS);

    typedef logic [1:0] quat_t;
    typedef quat_t [STG-1:0] qreg_t;

    // Stages summed into the new stage 7 of each binary register.
    localparam logic [STG-1:0] S_TAPS = 8'b1010_0011;
    localparam logic [STG-1:0] T_TAPS = 8'b1011_0001;

    // Z4 weights of stages 7..0 in the quaternary feedback.
    localparam qreg_t Q_COEF = {2'd0, 2'd0, 2'd3, 2'd0, 2'd1, 2'd3, 2'd2, 2'd3};

    // Spread field r into a quaternary seed that is odd in stage 0.
    function automatic qreg_t seed_quat(input logic [STG-1:0] r);
        qreg_t q;
        for (int k = 0; k < STG; k++) q[k] = {r[k], 1'b0};
        q[0][0] = 1'b1;
        return q;
    endfunction

    // Combine stage-0 values into one chip symbol, modulo 4.
    function automatic quat_t chip_sym(input quat_t a, input logic b, input logic c);
        return a + {b ^ c, 1'b0};
    endfunction
endpackage

// File: rtl/scr_bin_lfsr.sv
// Binary Fibonacci shift register. Stage 0 is the output. Each advance
// shifts toward stage 0 and fills stage 7 with the XOR of the tapped
// stages. Assumes load and adv never need to act together (load wins).
module scr_bin_lfsr #(
    parameter int               STG  = 8,
    parameter logic [STG-1:0]   TAPS = '1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [STG-1:0] seed,
    input  logic           adv,
    output logic           out_bit
);
    logic [STG-1:0] st_q;

    // Register state: clear, reseed or step.
    always_ff @(posedge clk) begin
        if (!rst_n)    st_q <= '0;
        else if (load) st_q <= seed;
        else if (adv)  st_q <= {^(st_q & TAPS), st_q[STG-1:1]};
    end

    assign out_bit = st_q[0];
endmodule

// File: rtl/scr_quat_lfsr.sv
// Shift register over Z4. Stage 0 is the output. The new stage 7 is the
// weighted sum of all stages modulo 4. After reset it holds the seed for
// field r = 0.
module scr_quat_lfsr
    import scr_pkg::*;
#(
    parameter qreg_t COEF = Q_COEF
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  qreg_t seed,
    input  logic  adv,
    output quat_t out_sym
);
    qreg_t st_q;
    quat_t fb;

    // Weighted feedback sum, wrapping naturally in two bits.
    always_comb begin
        fb = '0;
        for (int k = 0; k < STG; k++) fb = fb + quat_t'(COEF[k] * st_q[k]);
    end

    // Register state: reset seed, reseed or step.
    always_ff @(posedge clk) begin
        if (!rst_n)    st_q <= seed_quat('0);
        else if (load) st_q <= seed;
        else if (adv)  st_q <= {fb, st_q[STG-1:1]};
    end

    assign out_sym = st_q[0];
endmodule

// File: rtl/scr_chip_ctr.sv
// Chip position counter, 0 .. CHIPS-1, wrapping. Clear wins over step.
module scr_chip_ctr #(
    parameter int CHIPS = 256,
    localparam int CNT_W = $clog2(CHIPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHIPS - 1);

    // Count chips and wrap after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (step)  cnt <= at_last ? '0 : cnt + 1'b1;
    end

    assign at_last = (cnt == LAST);
endmodule

// File: rtl/scr_code_gen.sv
// Top: quaternary uplink scrambling code generator. Stores the user index
// fields, drives three shift registers, sums their outputs modulo 4,
// repeats chip 0 on the last chip and reseeds on the wrap. Assumes
// chip_en_i is a one-cycle-per-chip qualifier.
module scr_code_gen
    import scr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [IDX_W-1:0] user_idx_i,
    input  logic             chip_en_i,
    output logic [1:0]       sym_o,
    output logic             i_neg_o,
    output logic             q_neg_o,
    output logic [CNT_W-1:0] chip_cnt_o,
    output logic             period_start_o
);
    logic [IDX_W-1:0] fld_q;
    logic [IDX_W-1:0] fld_src;
    logic             at_last;
    logic             wrap_go;
    logic             reseed;
    logic             adv;
    quat_t            q_out;
    logic             s_out;
    logic             t_out;
    quat_t            first_sym;
    quat_t            live_sym;

    // Keep the fields of the selected user for every later reseed.
    always_ff @(posedge clk) begin
        if (!rst_n)      fld_q <= '0;
        else if (load_i) fld_q <= user_idx_i;
    end

    assign fld_src = load_i ? user_idx_i : fld_q;
    assign wrap_go = chip_en_i & at_last & ~load_i;
    assign reseed  = load_i | wrap_go;
    assign adv     = chip_en_i & ~at_last & ~load_i;

    scr_quat_lfsr u_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (reseed),
        .seed    (seed_quat(fld_src[STG-1:0])),
        .adv     (adv),
        .out_sym (q_out)
    );

    scr_bin_lfsr #(.STG(STG), .TAPS(S_TAPS)) u_s (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (reseed),
        .seed    (fld_src[2*STG-1:STG]),
        .adv     (adv),
        .out_bit (s_out)
    );

    scr_bin_lfsr #(.STG(STG), .TAPS(T_TAPS)) u_t (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (reseed),
        .seed    (fld_src[3*STG-1:2*STG]),
        .adv     (adv),
        .out_bit (t_out)
    );

    scr_chip_ctr #(.CHIPS(CHIPS)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load_i),
        .step    (chip_en_i),
        .cnt     (chip_cnt_o),
        .at_last (at_last)
    );

    // Chip-0 symbol of the stored user, taken straight from the seed bits.
    assign first_sym = chip_sym(2'd1, fld_q[STG], fld_q[2*STG] ^ fld_q[0]);
    assign live_sym  = chip_sym(q_out, s_out, t_out);

    // Pick the repeated chip on the last position and map it to signs.
    always_comb begin
        sym_o   = at_last ? first_sym : live_sym;
        i_neg_o = sym_o[1] ^ sym_o[0];
        q_neg_o = sym_o[1];
    end

    assign period_start_o = (chip_cnt_o == '0);
endmodule

// File: rtl/scr_code_gen_chk.sv
// Checker: temporal properties of the generator's ports, bound to the top.
module scr_code_gen_chk
    import scr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic             chip_en_i,
    input logic [1:0]       sym_o,
    input logic             i_neg_o,
    input logic             q_neg_o,
    input logic [CNT_W-1:0] chip_cnt_o,
    input logic             period_start_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHIPS - 1);

    p_load_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (chip_cnt_o == '0) && period_start_o);

    p_chip_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en_i && !load_i && chip_cnt_o != LAST) |=> chip_cnt_o == $past(chip_cnt_o) + 1'b1);

    p_wrap_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en_i && !load_i && chip_cnt_o == LAST) |=> period_start_o);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en_i && !load_i) |=> $stable(sym_o) && $stable(chip_cnt_o)
                                    && $stable(i_neg_o) && $stable(q_neg_o));

    p_odd_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        period_start_o |-> sym_o[0]);

    p_odd_repeat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_cnt_o == LAST) |-> sym_o[0]);
endmodule

bind scr_code_gen scr_code_gen_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .load_i         (load_i),
    .chip_en_i      (chip_en_i),
    .sym_o          (sym_o),
    .i_neg_o        (i_neg_o),
    .q_neg_o        (q_neg_o),
    .chip_cnt_o     (chip_cnt_o),
    .period_start_o (period_start_o)
);

// File: tb/scr_code_gen_bench.sv
module scr_code_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [23:0] user_idx_i = '0;
    logic        chip_en_i = 1'b0;
    logic [1:0]  sym_o;
    logic        i_neg_o;
    logic        q_neg_o;
    logic [7:0]  chip_cnt_o;
    logic        period_start_o;

    int vectors = 0;
    int miscompares = 0;
    bit armed = 1'b0;
    string phase = "R1";

    scr_code_gen u_scr_code_gen (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .user_idx_i(user_idx_i),
        .chip_en_i(chip_en_i), .sym_o(sym_o), .i_neg_o(i_neg_o), .q_neg_o(q_neg_o),
        .chip_cnt_o(chip_cnt_o), .period_start_o(period_start_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: integer stage arrays and stored fields.
    int ma[8];
    int mb[8];
    int mc[8];
    int mcnt;
    int fr, fs, ft;
    int z0;

    function automatic int cur_sym();
        return (ma[0] + 2 * mb[0] + 2 * mc[0]) % 4;
    endfunction

    task automatic m_seed();
        for (int k = 0; k < 8; k++) begin
            ma[k] = 2 * ((fr >> k) & 1);
            mb[k] = (fs >> k) & 1;
            mc[k] = (ft >> k) & 1;
        end
        ma[0] = ma[0] + 1;
        mcnt = 0;
        z0 = cur_sym();
    endtask

    task automatic m_adv();
        int na, nb, nc;
        na = (3 * ma[5] + ma[3] + 3 * ma[2] + 2 * ma[1] + 3 * ma[0]) % 4;
        nb = mb[7] ^ mb[5] ^ mb[1] ^ mb[0];
        nc = mc[7] ^ mc[5] ^ mc[4] ^ mc[0];
        for (int k = 0; k < 7; k++) begin
            ma[k] = ma[k+1];
            mb[k] = mb[k+1];
            mc[k] = mc[k+1];
        end
        ma[7] = na;
        mb[7] = nb;
        mc[7] = nc;
        mcnt++;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            fr = 0; fs = 0; ft = 0;
            m_seed();
        end else if (load_i) begin
            fr = int'(user_idx_i[7:0]);
            fs = int'(user_idx_i[15:8]);
            ft = int'(user_idx_i[23:16]);
            m_seed();
        end else if (chip_en_i) begin
            if (mcnt == 255) m_seed();
            else m_adv();
        end
    end

    task automatic compare();
        int es;
        bit ei, eq, ep;
        string tg;
        es = (mcnt == 255) ? z0 : cur_sym();
        ei = (es == 1) || (es == 2);
        eq = (es == 2) || (es == 3);
        ep = (mcnt == 0);
        tg = (mcnt == 255) ? "R6" : (mcnt == 0) ? "R4" : "R5";
        vectors++;
        if (int'(sym_o) != es) begin
            miscompares++;
            $display("FAIL %s (phase %s) sym chip %0d: actual %0d expected %0d", tg, phase, mcnt, sym_o, es);
        end
        if (int'(chip_cnt_o) != mcnt) begin
            miscompares++;
            $display("FAIL R7 (phase %s) chip count: actual %0d expected %0d", phase, chip_cnt_o, mcnt);
        end
        if (period_start_o != ep) begin
            miscompares++;
            $display("FAIL R7 (phase %s) period start: actual %0b expected %0b", phase, period_start_o, ep);
        end
        if (i_neg_o != ei || q_neg_o != eq) begin
            miscompares++;
            $display("FAIL R8 (phase %s) signs for %0d: actual %0b%0b expected %0b%0b", phase, es, i_neg_o, q_neg_o, ei, eq);
        end
    endtask

    always @(negedge clk) if (armed) compare();

    task automatic run(input int n, input int en_pct);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            chip_en_i = ($urandom_range(99) < en_pct);
        end
    endtask

    task automatic do_load(input logic [23:0] idx, input bit en);
        @(posedge clk);
        #1;
        load_i = 1'b1;
        user_idx_i = idx;
        chip_en_i = en;
        @(posedge clk);
        #1;
        load_i = 1'b0;
        user_idx_i = ~idx;
        chip_en_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        armed = 1'b1;
        // R1: reset state, then index 0 running across two wraps (R7, R6).
        phase = "R1";
        run(600, 100);
        // R2 R3 R4 R5: several users, full enable.
        phase = "R2";
        do_load(24'hABCDEF, 1'b0); run(300, 100);
        do_load(24'h000001, 1'b1); run(300, 100);
        do_load(24'hFFFFFF, 1'b0); run(300, 100);
        do_load(24'h123456, 1'b1); run(300, 100);
        do_load(24'h80FF01, 1'b1); run(300, 100);
        do_load(24'h010000, 1'b0); run(300, 100);
        do_load(24'h000100, 1'b0); run(300, 100);
        // R9: gated enable, wraps landing while enable toggles.
        phase = "R9";
        do_load(24'h5A3C96, 1'b0); run(1200, 40);
        run(30, 0);
        // R6: stall and then reload exactly on chip 255.
        phase = "R6";
        do_load(24'hC0FFEE, 1'b0);
        @(posedge clk); #1; chip_en_i = 1'b1;
        repeat (255) @(posedge clk);
        #1; chip_en_i = 1'b0;
        run(10, 0);
        do_load(24'h7E1D42, 1'b1); run(520, 100);
        // R2: load on a random position with enable, reset over a load.
        phase = "R2";
        run(77, 100);
        do_load(24'h3F00C1, 1'b1); run(200, 70);
        @(posedge clk); #1;
        rst_n = 1'b0; load_i = 1'b1; user_idx_i = 24'hFFFFFF;
        @(posedge clk); #1;
        rst_n = 1'b1; load_i = 1'b0;
        phase = "R1";
        run(300, 100);
        @(negedge clk);
        armed = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule